// File: doc/BRIEF.md
# Processor Power-State Controller

This block is the sequencing logic that tracks a processor core's low-power condition. It follows the core from full operation into a halted, clock-gated idle, into a granted clock-stop and from there into a fully stopped input clock. From two of those idle states it also takes short excursions to answer an external cache snoop or a write-back flush. The pipeline, the cache arrays and the bus are not part of the block. They appear only as strobes and request/done handshakes at its ports.

The controller tells the rest of the core three things. It says when to run the core clock and when to float the bus. It drives the hit-modified indication during a dirty snoop. It also says when to issue a special bus cycle, using single-cycle pulses for halt, stop-grant and flush-acknowledge. Each pulse appears in the first cycle of the state it announces.

A snoop or flush excursion remembers the state it left and returns there. Leaving a flush re-announces a halted state with a fresh halt cycle. Leaving a snoop announces nothing.

Top module: `pwr_state_ctrl`

## Requirements
- R1: With `rst_n` low, or one cycle after `cpu_reset` is sampled high in any state, `cur_state` is Normal (0) and every cycle-request pulse is low. `cpu_reset` outranks every other event.
- R2: `cur_state` uses this encoding: Normal 0, Auto-Halt 1, Stop-Grant 2, Stop-Clock 3, Snoop 4, Flush 5. `core_clk_en` is high in 0, 4 and 5 and low in 1, 2 and 3.
- R3: `halt_exec` in Normal moves to Auto-Halt. `cyc_halt` is high for exactly the first Auto-Halt cycle.
- R4: Auto-Halt is left for Normal only by `intr`, `nmi`, `smi`, `soft_reset` or a held-pending interrupt, with no cycle pulse. Without these it stays in Auto-Halt.
- R5: `stpclk_req` in Normal or Auto-Halt enters Stop-Grant with one `cyc_stop_grant` pulse. When `stpclk_req` drops, the controller returns to the state it came from, and pulses `cyc_halt` only when that state is Auto-Halt.
- R6: Stop-Clock is entered only from Stop-Grant while `clk_stopped` is high, and is left for Stop-Grant when `clk_stopped` falls. An `intr` seen in Stop-Clock is held pending and later wakes Auto-Halt to Normal.
- R7: `eads` in Auto-Halt or Stop-Grant enters Snoop. With no hit, Snoop lasts one cycle with the core clock on, then returns to the prior state with no cycle pulse.
- R8: A `snoop_hit` in Snoop raises `hitm`. `hitm` stays high through the cycle in which `wb_done` is seen. The return to the prior state follows on the next cycle, with no pulse.
- R9: `bus_float` is high exactly while the state is Auto-Halt or Stop-Grant and any of `hold`, `ahold` or `boff` is high.
- R10: With `wb_mode` high, `flush_req` in Normal or Auto-Halt enters Flush. On `flush_done` the controller returns to the prior state and pulses `cyc_flush_ack`. It also pulses `cyc_halt` when that prior state is Auto-Halt.
- R11: When events coincide in Auto-Halt, the precedence is flush, then snoop, then stop-clock request, then interrupt.
- R12: `flush_req` has no effect when `wb_mode` is low, or in Stop-Grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| halt_exec | input | 1 | Strobe: core executed a halt |
| stpclk_req | input | 1 | Level: system asks for clock stop |
| clk_stopped | input | 1 | Level: input clock is stopped |
| intr | input | 1 | Maskable interrupt |
| nmi | input | 1 | Non-maskable interrupt |
| smi | input | 1 | System-management interrupt |
| cpu_reset | input | 1 | Hard reset event |
| soft_reset | input | 1 | Soft reset event |
| hold | input | 1 | Bus hold request |
| ahold | input | 1 | Address hold request |
| boff | input | 1 | Bus back-off request |
| eads | input | 1 | External snoop strobe |
| snoop_hit | input | 1 | Snoop hit a modified line |
| wb_done | input | 1 | Snoop write-back finished |
| flush_req | input | 1 | Cache flush request |
| flush_done | input | 1 | Cache flush finished |
| wb_mode | input | 1 | Cache is in write-back mode |
| cyc_halt | output | 1 | One-cycle halt special-cycle request |
| cyc_stop_grant | output | 1 | One-cycle stop-grant special-cycle request |
| cyc_flush_ack | output | 1 | One-cycle flush-acknowledge request |
| bus_float | output | 1 | Float the bus |
| core_clk_en | output | 1 | Core clock enable |
| hitm | output | 1 | Snoop hit a modified line, write-back pending |
| cur_state | output | 3 | Current power state (R2 encoding) |

## Verification
The assertions assume that `snoop_hit` is meaningful only during Snoop and that `wb_done` and `flush_done` arrive only while their handshakes are open. They also assume that `clk_stopped` rises only after Stop-Grant has been reached. The stimulus drives each handshake input only in the state that owns it and clears it right after use. It returns the controller to Normal through `cpu_reset` between scenarios, so every sweep point starts from a known state. The priority sweep covers all sixteen combinations of flush, snoop, stop request and interrupt in Auto-Halt.

// File: rtl/pwr_pkg.sv
`timescale 1ns/1ps
package pwr_pkg;
  localparam int STATE_W = 3;
  localparam int EVT_W   = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_NORMAL = 3'd0,
    ST_AHALT  = 3'd1,
    ST_SGRANT = 3'd2,
    ST_SCLOCK = 3'd3,
    ST_SNOOP  = 3'd4,
    ST_FLUSH  = 3'd5
  } pstate_e;

  typedef enum logic [EVT_W-1:0] {
    EV_NONE, EV_RESET, EV_FLUSH, EV_SNOOP, EV_STOP, EV_RESUME,
    EV_FREEZE, EV_THAW, EV_WAKE, EV_HALT, EV_DONE
  } pevt_e;

  // states in which the core clock runs
  function automatic logic clk_running(input pstate_e s);
    return (s == ST_NORMAL) || (s == ST_SNOOP) || (s == ST_FLUSH);
  endfunction

  // idle states that accept snoops and bus holds
  function automatic logic is_parked(input pstate_e s);
    return (s == ST_AHALT) || (s == ST_SGRANT);
  endfunction
endpackage

// File: rtl/pwr_evt_arb.sv
`timescale 1ns/1ps
module pwr_evt_arb
  import pwr_pkg::*;
(
  input  pstate_e st,
  input  logic    cpu_reset,
  input  logic    flush_req,
  input  logic    wb_mode,
  input  logic    eads,
  input  logic    stpclk_req,
  input  logic    clk_stopped,
  input  logic    wake_any,
  input  logic    halt_exec,
  input  logic    hitm_now,
  input  logic    wb_done,
  input  logic    flush_done,
  output pevt_e   evt
);
  logic flush_ok;
  assign flush_ok = flush_req && wb_mode;

  always_comb begin
    evt = EV_NONE;
    if (cpu_reset) begin
      evt = EV_RESET;
    end else begin
      unique case (st)
        ST_NORMAL: begin
          if (flush_ok)        evt = EV_FLUSH;
          else if (stpclk_req) evt = EV_STOP;
          else if (halt_exec)  evt = EV_HALT;
        end
        ST_AHALT: begin
          if (flush_ok)        evt = EV_FLUSH;
          else if (eads)       evt = EV_SNOOP;
          else if (stpclk_req) evt = EV_STOP;
          else if (wake_any)   evt = EV_WAKE;
        end
        ST_SGRANT: begin
          if (eads)             evt = EV_SNOOP;
          else if (clk_stopped) evt = EV_FREEZE;
          else if (!stpclk_req) evt = EV_RESUME;
        end
        ST_SCLOCK: begin
          if (!clk_stopped) evt = EV_THAW;
        end
        ST_SNOOP: begin
          if (!hitm_now || wb_done) evt = EV_DONE;
        end
        ST_FLUSH: begin
          if (flush_done) evt = EV_DONE;
        end
        default: evt = EV_RESET;
      endcase
    end
  end
endmodule

// File: rtl/pwr_fsm_core.sv
`timescale 1ns/1ps
module pwr_fsm_core
  import pwr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pevt_e   evt,
  input  logic    intr,
  input  logic    snoop_hit,
  output pstate_e st,
  output logic    pend,
  output logic    wb_busy,
  output logic    cyc_halt,
  output logic    cyc_sg,
  output logic    cyc_fack
);
  pstate_e snoop_ret, flush_ret;
  logic    sg_from_halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_NORMAL;
      snoop_ret    <= ST_AHALT;
      flush_ret    <= ST_NORMAL;
      sg_from_halt <= 1'b0;
      pend         <= 1'b0;
      wb_busy      <= 1'b0;
      cyc_halt     <= 1'b0;
      cyc_sg       <= 1'b0;
      cyc_fack     <= 1'b0;
    end else begin
      cyc_halt <= 1'b0;
      cyc_sg   <= 1'b0;
      cyc_fack <= 1'b0;
      if (st == ST_SCLOCK && intr) pend <= 1'b1;
      unique case (evt)
        EV_RESET: begin
          st           <= ST_NORMAL;
          pend         <= 1'b0;
          wb_busy      <= 1'b0;
          sg_from_halt <= 1'b0;
        end
        EV_FLUSH: begin
          flush_ret <= st;
          st        <= ST_FLUSH;
        end
        EV_SNOOP: begin
          snoop_ret <= st;
          wb_busy   <= 1'b0;
          st        <= ST_SNOOP;
        end
        EV_STOP: begin
          sg_from_halt <= (st == ST_AHALT);
          st           <= ST_SGRANT;
          cyc_sg       <= 1'b1;
        end
        EV_RESUME: begin
          if (sg_from_halt) begin
            st       <= ST_AHALT;
            cyc_halt <= 1'b1;
          end else begin
            st   <= ST_NORMAL;
            pend <= 1'b0;
          end
        end
        EV_FREEZE: st <= ST_SCLOCK;
        EV_THAW:   st <= ST_SGRANT;
        EV_WAKE: begin
          st   <= ST_NORMAL;
          pend <= 1'b0;
        end
        EV_HALT: begin
          st       <= ST_AHALT;
          cyc_halt <= 1'b1;
        end
        EV_DONE: begin
          if (st == ST_SNOOP) begin
            st      <= snoop_ret;
            wb_busy <= 1'b0;
          end else begin
            st       <= flush_ret;
            cyc_fack <= 1'b1;
            cyc_halt <= (flush_ret == ST_AHALT);
          end
        end
        default: begin
          if (st == ST_SNOOP && snoop_hit) wb_busy <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pwr_out_dec.sv
`timescale 1ns/1ps
module pwr_out_dec
  import pwr_pkg::*;
(
  input  pstate_e st,
  input  logic    wb_busy,
  input  logic    snoop_hit,
  input  logic    hold,
  input  logic    ahold,
  input  logic    boff,
  output logic    core_clk_en,
  output logic    bus_float,
  output logic    hitm
);
  assign core_clk_en = clk_running(st);
  assign bus_float   = is_parked(st) && (hold || ahold || boff);
  assign hitm        = (st == ST_SNOOP) && (wb_busy || snoop_hit);
endmodule

// File: rtl/pwr_state_ctrl.sv
`timescale 1ns/1ps
module pwr_state_ctrl
  import pwr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_exec,
  input  logic               stpclk_req,
  input  logic               clk_stopped,
  input  logic               intr,
  input  logic               nmi,
  input  logic               smi,
  input  logic               cpu_reset,
  input  logic               soft_reset,
  input  logic               hold,
  input  logic               ahold,
  input  logic               boff,
  input  logic               eads,
  input  logic               snoop_hit,
  input  logic               wb_done,
  input  logic               flush_req,
  input  logic               flush_done,
  input  logic               wb_mode,
  output logic               cyc_halt,
  output logic               cyc_stop_grant,
  output logic               cyc_flush_ack,
  output logic               bus_float,
  output logic               core_clk_en,
  output logic               hitm,
  output logic [STATE_W-1:0] cur_state
);
  pstate_e st;
  pevt_e   evt;
  logic    pend, wb_busy, wake_any;

  assign wake_any  = intr || nmi || smi || soft_reset || pend;
  assign cur_state = st;

  pwr_evt_arb u_arb (
    .st(st), .cpu_reset(cpu_reset), .flush_req(flush_req), .wb_mode(wb_mode),
    .eads(eads), .stpclk_req(stpclk_req), .clk_stopped(clk_stopped),
    .wake_any(wake_any), .halt_exec(halt_exec), .hitm_now(hitm),
    .wb_done(wb_done), .flush_done(flush_done), .evt(evt)
  );

  pwr_fsm_core u_core (
    .clk(clk), .rst_n(rst_n), .evt(evt), .intr(intr), .snoop_hit(snoop_hit),
    .st(st), .pend(pend), .wb_busy(wb_busy), .cyc_halt(cyc_halt),
    .cyc_sg(cyc_stop_grant), .cyc_fack(cyc_flush_ack)
  );

  pwr_out_dec u_dec (
    .st(st), .wb_busy(wb_busy), .snoop_hit(snoop_hit), .hold(hold),
    .ahold(ahold), .boff(boff), .core_clk_en(core_clk_en),
    .bus_float(bus_float), .hitm(hitm)
  );
endmodule

// File: rtl/pwr_state_chk.sv
`timescale 1ns/1ps
module pwr_state_chk
  import pwr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_reset,
  input logic               hold,
  input logic               ahold,
  input logic               boff,
  input logic               cyc_halt,
  input logic               cyc_stop_grant,
  input logic               cyc_flush_ack,
  input logic               bus_float,
  input logic               core_clk_en,
  input logic               hitm,
  input logic [STATE_W-1:0] cur_state
);
  logic parked;
  assign parked = (cur_state == ST_AHALT) || (cur_state == ST_SGRANT);

  p_reset_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset |=> (cur_state == ST_NORMAL));
  p_clk_en_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en == ((cur_state == ST_NORMAL) || (cur_state == ST_SNOOP) || (cur_state == ST_FLUSH)));
  p_halt_in_ahalt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_halt |-> (cur_state == ST_AHALT));
  p_halt_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_halt |=> !cyc_halt);
  p_sg_in_sgrant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_stop_grant |-> (cur_state == ST_SGRANT));
  p_sclock_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_state == ST_SCLOCK) && ($past(cur_state) != ST_SCLOCK)) |-> ($past(cur_state) == ST_SGRANT));
  p_snoop_brief_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_state == ST_SNOOP) && !hitm) |=> (cur_state != ST_SNOOP));
  p_hitm_in_snoop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hitm |-> (cur_state == ST_SNOOP));
  p_float_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_float == (parked && (hold || ahold || boff)));
  p_fack_after_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_flush_ack |-> ($past(cur_state) == ST_FLUSH));
endmodule

bind pwr_state_ctrl pwr_state_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_reset(cpu_reset), .hold(hold), .ahold(ahold),
  .boff(boff), .cyc_halt(cyc_halt), .cyc_stop_grant(cyc_stop_grant),
  .cyc_flush_ack(cyc_flush_ack), .bus_float(bus_float),
  .core_clk_en(core_clk_en), .hitm(hitm), .cur_state(cur_state)
);

// File: tb/tb_pwr_state_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_state_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_exec = 0, stpclk_req = 0, clk_stopped = 0, intr = 0, nmi = 0, smi = 0;
  logic cpu_reset = 0, soft_reset = 0, hold = 0, ahold = 0, boff = 0, eads = 0;
  logic snoop_hit = 0, wb_done = 0, flush_req = 0, flush_done = 0, wb_mode = 0;
  logic cyc_halt, cyc_stop_grant, cyc_flush_ack, bus_float, core_clk_en, hitm;
  logic [2:0] cur_state;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_state_ctrl dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic to_ahalt();
    halt_exec = 1; tick(); halt_exec = 0;
  endtask

  task automatic hard_rst();
    cpu_reset = 1; tick(); cpu_reset = 0;
    {halt_exec, stpclk_req, clk_stopped, intr, nmi, smi, soft_reset} = '0;
    {hold, ahold, boff, eads, snoop_hit, wb_done, flush_req, flush_done} = '0;
    chk("R1 reset to normal", cur_state, 0);
  endtask

  function automatic int clk_exp(input int s);
    return (s == 0 || s == 4 || s == 5) ? 1 : 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R1 state in reset", cur_state, 0);
    chk("R1 pulses in reset", {cyc_halt, cyc_stop_grant, cyc_flush_ack}, 0);
    chk("R2 clk_en normal", core_clk_en, 1);
    rst_n = 1; tick();

    // R3
    to_ahalt();
    chk("R3 ahalt entered", cur_state, 1);
    chk("R3 halt pulse", cyc_halt, 1);
    chk("R2 clk_en ahalt", core_clk_en, clk_exp(1));
    tick();
    chk("R3 halt pulse single", cyc_halt, 0);
    hard_rst();

    // R4 wake sources, R9 bus float
    for (int s = 0; s < 7; s++) begin
      to_ahalt(); tick();
      chk("R4 stays halted", cur_state, 1);
      case (s)
        0: intr = 1;
        1: nmi = 1;
        2: smi = 1;
        3: soft_reset = 1;
        4: hold = 1;
        5: ahold = 1;
        default: boff = 1;
      endcase
      #1;
      chk("R9 float follows hold", bus_float, (s >= 4) ? 1 : 0);
      tick();
      chk("R4 wake result", cur_state, (s < 4) ? 0 : 1);
      chk("R4 no pulse on wake", cyc_halt, 0);
      hard_rst();
    end
    hold = 1; #1;
    chk("R9 no float in normal", bus_float, 0);
    hold = 0;

    // R5 from normal and from ahalt
    stpclk_req = 1; tick();
    chk("R5 sgrant from normal", cur_state, 2);
    chk("R5 sg pulse", cyc_stop_grant, 1);
    boff = 1; tick();
    chk("R5 sg pulse single", cyc_stop_grant, 0);
    chk("R9 float in sgrant", bus_float, 1);
    boff = 0; intr = 1; tick();
    chk("R11 intr ignored in sgrant", cur_state, 2);
    intr = 0; stpclk_req = 0; tick();
    chk("R5 back to normal", cur_state, 0);
    chk("R5 no halt pulse to normal", cyc_halt, 0);
    to_ahalt(); stpclk_req = 1; tick();
    chk("R5 sgrant from ahalt", cur_state, 2);
    chk("R5 sg pulse from ahalt", cyc_stop_grant, 1);
    stpclk_req = 0; tick();
    chk("R5 back to ahalt", cur_state, 1);
    chk("R5 fresh halt pulse", cyc_halt, 1);

    // R6 stop clock, pending interrupt
    stpclk_req = 1; tick();
    clk_stopped = 1; tick();
    chk("R6 stop clock", cur_state, 3);
    chk("R2 clk_en sclock", core_clk_en, clk_exp(3));
    intr = 1; tick(); intr = 0; tick();
    chk("R6 still stopped", cur_state, 3);
    clk_stopped = 0; tick();
    chk("R6 thaw to sgrant", cur_state, 2);
    stpclk_req = 0; tick();
    chk("R6 resume ahalt", cur_state, 1);
    tick();
    chk("R6 pending intr wakes", cur_state, 0);
    to_ahalt(); tick();
    chk("R6 pending cleared", cur_state, 1);

    // R7 snoop without hit, from ahalt and sgrant
    eads = 1; tick(); eads = 0;
    chk("R7 snoop entered", cur_state, 4);
    chk("R7 clk on in snoop", core_clk_en, 1);
    chk("R7 no hitm", hitm, 0);
    tick();
    chk("R7 back to ahalt", cur_state, 1);
    chk("R7 no halt pulse", cyc_halt, 0);
    stpclk_req = 1; tick();
    eads = 1; tick(); eads = 0;
    chk("R7 snoop from sgrant", cur_state, 4);
    tick();
    chk("R7 back to sgrant", cur_state, 2);
    chk("R7 no sg pulse", cyc_stop_grant, 0);
    stpclk_req = 0; tick();
    chk("R5 sgrant memory kept", cur_state, 1);

    // R8 snoop hit with write-back
    eads = 1; tick(); eads = 0; snoop_hit = 1; #1;
    chk("R8 hitm on hit", hitm, 1);
    tick(); snoop_hit = 0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R8 hitm held", hitm, 1);
      chk("R8 stay in snoop", cur_state, 4);
    end
    wb_done = 1; #1;
    chk("R8 hitm through done", hitm, 1);
    tick(); wb_done = 0;
    chk("R8 return after wb", cur_state, 1);
    chk("R8 hitm released", hitm, 0);
    chk("R8 no pulse", cyc_halt, 0);
    hard_rst();

    // R10/R12 flush
    flush_req = 1; tick();
    chk("R12 flush ignored without wb", cur_state, 0);
    wb_mode = 1; tick(); flush_req = 0;
    chk("R10 flush from normal", cur_state, 5);
    tick();
    chk("R10 wait flush", cur_state, 5);
    flush_done = 1; tick(); flush_done = 0;
    chk("R10 back to normal", cur_state, 0);
    chk("R10 flush ack", cyc_flush_ack, 1);
    chk("R10 no halt to normal", cyc_halt, 0);
    to_ahalt(); flush_req = 1; tick(); flush_req = 0;
    chk("R10 flush from ahalt", cur_state, 5);
    flush_done = 1; tick(); flush_done = 0;
    chk("R10 back to ahalt", cur_state, 1);
    chk("R10 ack from ahalt", cyc_flush_ack, 1);
    chk("R10 halt reissued", cyc_halt, 1);
    stpclk_req = 1; tick(); flush_req = 1; tick();
    chk("R12 flush ignored in sgrant", cur_state, 2);
    hard_rst();

    // R11 priority sweep in ahalt, R1 reset beats all
    for (int v = 0; v < 16; v++) begin
      int e;
      to_ahalt();
      flush_req = v[3]; eads = v[2]; stpclk_req = v[1]; intr = v[0];
      tick();
      e = v[3] ? 5 : v[2] ? 4 : v[1] ? 2 : v[0] ? 0 : 1;
      chk("R11 priority", cur_state, e);
      chk("R2 clk_en sweep", core_clk_en, clk_exp(e));
      hard_rst();
    end
    to_ahalt(); flush_req = 1; eads = 1; stpclk_req = 1; cpu_reset = 1; tick();
    chk("R1 reset beats all", cur_state, 0);
    cpu_reset = 0;
    hard_rst();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule